// File: doc/BRIEF.md
# Synchronous FIFO with Read Rewind

This block is a single-clock first-in/first-out buffer for 9-bit words. Its depth is a parameter (256, 512 or 1024 words). A write strobe stores a word and a read strobe fetches one. The block drives three status flags: empty, full and half-full. A strobe that the current fill level cannot honour has no effect.

Read data is registered. A separate valid qualifier marks the cycle in which the data is meaningful, so no bus is ever left floating.

A mode input selects one of two modes:
- **Single mode.** A rewind input sends the read pointer back to the first location written since reset. Everything written since reset can then be read again. The half-full flag is driven in this mode.
- **Expansion mode.** The same input only marks the first-loaded device and has no effect here. The half-full flag is held low.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `empty_o` is 1, `full_o` is 0, `half_o` is 0 and `rd_valid_o` is 0.
- R2: Words come out in the order they were accepted. A read accepted at a clock edge presents its word on `rd_data_o` with `rd_valid_o` = 1 after that edge. `rd_valid_o` is 0 after any edge with no accepted read.
- R3: `full_o` asserts after DEPTH accepted writes with no read. While `full_o` is 1 a write is discarded, and the stored contents and the write pointer stay unchanged.
- R4: While `empty_o` is 1 a read strobe is ignored. `rd_valid_o` stays 0 and the read pointer does not move.
- R5: The last stored word is delivered by the read that empties the FIFO, and `empty_o` is 1 after that edge. After an accepted write, `empty_o` is 0.
- R6: `half_o` rises on the write that takes the occupancy from DEPTH/2 to DEPTH/2+1. It falls on the read that takes the occupancy from DEPTH/2+1 to DEPTH/2.
- R7: In single mode (`single_i` = 1), a one-cycle `rt_i` pulse with both strobes idle sets the read pointer to the first location and leaves the write pointer unchanged. The occupancy becomes the number of writes accepted since reset, and `empty_o`, `full_o` and `half_o` follow that occupancy.
- R8: In expansion mode (`single_i` = 0), `rt_i` has no effect and `half_o` is 0.
- R9: A read and a write in the same cycle leave the occupancy unchanged. If the FIFO is empty, only the write takes effect. If it is full, only the read takes effect.
- R10: An `rt_i` pulse in single mode while `wr_i` or `rd_i` is high does not rewind anything. `rt_err_o` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | 9 | Write word |
| rd_i | input | 1 | Read strobe |
| rt_i | input | 1 | Rewind request (first-load marker in expansion mode) |
| single_i | input | 1 | 1 = single mode, 0 = expansion mode |
| rd_data_o | output | 9 | Read word |
| rd_valid_o | output | 1 | `rd_data_o` holds a freshly read word |
| empty_o | output | 1 | Occupancy is zero |
| full_o | output | 1 | Occupancy is DEPTH |
| half_o | output | 1 | Occupancy above DEPTH/2 (single mode) |
| rt_err_o | output | 1 | Rewind requested while a strobe is active |

## Verification
The bench fills the FIFO to exactly DEPTH words and then keeps writing. A design that lets the write pointer wrap would overwrite the oldest word, and the drain sequence would show the damage. The bench also strobes read and write together on an empty FIFO and on a full one. A design that counts the blocked side would drift its occupancy by one, and empty or full would go wrong later.

Two checks walk the half-full boundary one word at a time in each direction, catching an off-by-one in the set or clear event. The rewind is tested in four situations:
- after the FIFO was drained, so the recomputed flags must reassert half-full;
- in expansion mode, where a rewind must not move the read pointer;
- together with a read strobe, where a design without the guard would rewind;
- in every case the next word read shows whether the pointer moved.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
  localparam int unsigned WORD_W = 9;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic wr;
    logic rd;
    logic rt;
  } fifo_op_t;
endpackage

// File: rtl/rewind_fifo_ctrl.sv
module rewind_fifo_ctrl
  import rewind_fifo_pkg::*;
(
  input  logic     wr_i,
  input  logic     rd_i,
  input  logic     rt_i,
  input  logic     single_i,
  input  logic     empty_i,
  input  logic     full_i,
  output fifo_op_t op_o,
  output logic     rt_err_o
);
  logic rt_req;

  assign rt_req   = rt_i & single_i;
  assign op_o.wr  = wr_i & ~full_i;
  assign op_o.rd  = rd_i & ~empty_i;
  // rewind only with both strobes idle
  assign op_o.rt  = rt_req & ~wr_i & ~rd_i;
  assign rt_err_o = rt_req & (wr_i | rd_i);
endmodule

// File: rtl/rewind_fifo_ptrs.sv
module rewind_fifo_ptrs
  import rewind_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fifo_op_t      op_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] wcount_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o   <= '0;
      wcount_o <= '0;
    end else if (op_i.wr) begin
      wptr_o <= wptr_o + 1'b1;
      if (wcount_o != CNT_MAX) wcount_o <= wcount_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rptr_o <= '0;
    else if (op_i.rt)  rptr_o <= '0;
    else if (op_i.rd)  rptr_o <= rptr_o + 1'b1;
  end
endmodule

// File: rtl/rewind_fifo_flags.sv
module rewind_fifo_flags
  import rewind_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fifo_op_t      op_i,
  input  logic          single_i,
  input  logic [CW-1:0] wcount_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_o
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

  logic [CW-1:0] cnt_q;
  logic          half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (op_i.rt) begin
      cnt_q  <= wcount_i;
      half_q <= wcount_i > CNT_HALF;
    end else if (op_i.wr && !op_i.rd) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_HALF) half_q <= 1'b1;
    end else if (op_i.rd && !op_i.wr) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_HALF + 1'b1) half_q <= 1'b0;
    end
  end

  assign empty_o = cnt_q == '0;
  assign full_o  = cnt_q == CNT_MAX;
  assign half_o  = half_q & single_i;
endmodule

// File: rtl/rewind_fifo_mem.sv
module rewind_fifo_mem
  import rewind_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output word_t         rdata_o,
  output logic          rvalid_o
);
  word_t store [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= store[raddr_i];
    end
  end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [8:0]  wr_data_i,
  input  logic        rd_i,
  input  logic        rt_i,
  input  logic        single_i,
  output logic [8:0]  rd_data_o,
  output logic        rd_valid_o,
  output logic        empty_o,
  output logic        full_o,
  output logic        half_o,
  output logic        rt_err_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  fifo_op_t      op;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] wcount;

  rewind_fifo_ctrl i_ctrl (
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .rt_i     (rt_i),
    .single_i (single_i),
    .empty_i  (empty_o),
    .full_i   (full_o),
    .op_o     (op),
    .rt_err_o (rt_err_o)
  );

  rewind_fifo_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wptr_o   (wptr),
    .rptr_o   (rptr),
    .wcount_o (wcount)
  );

  rewind_fifo_flags #(.DEPTH(DEPTH)) i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .single_i (single_i),
    .wcount_i (wcount),
    .empty_o  (empty_o),
    .full_o   (full_o),
    .half_o   (half_o)
  );

  rewind_fifo_mem #(.DEPTH(DEPTH)) i_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (op.wr),
    .waddr_i  (wptr),
    .wdata_i  (wr_data_i),
    .re_i     (op.rd),
    .raddr_i  (rptr),
    .rdata_o  (rd_data_o),
    .rvalid_o (rd_valid_o)
  );
endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic rd_i,
  input logic rt_i,
  input logic single_i,
  input logic rd_valid_o,
  input logic empty_o,
  input logic full_o,
  input logic half_o,
  input logic rt_err_o
);
  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !rd_i |=> full_o); // R3
  AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !empty_o |=> rd_valid_o); // R2
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i |=> !rd_valid_o); // R4
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i |=> !empty_o); // R5
  AST_EXPANSION_NO_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_i |-> !half_o); // R8
  AST_RT_ERR_EMPTY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_err_o && empty_o && !wr_i |=> empty_o); // R10
endmodule

bind rewind_fifo rewind_fifo_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rt_i       (rt_i),
  .single_i   (single_i),
  .rd_valid_o (rd_valid_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .half_o     (half_o),
  .rt_err_o   (rt_err_o)
);

// File: tb/test_rewind_fifo.sv
`timescale 1ns/1ps
module test_rewind_fifo;
  localparam int DEPTH = 256;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, rt_i = 1'b0, single_i = 1'b1;
  logic [8:0] wr_data_i = '0;
  logic [8:0] rd_data_o;
  logic       rd_valid_o, empty_o, full_o, half_o, rt_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rewind_fifo #(.DEPTH(DEPTH)) i_rewind_fifo (
    .clk_i, .rst_ni, .wr_i, .wr_data_i, .rd_i, .rt_i, .single_i,
    .rd_data_o, .rd_valid_o, .empty_o, .full_o, .half_o, .rt_err_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    wr_i = 0; rd_i = 0; rt_i = 0;
    rst_ni = 0;
    step(); step();
    rst_ni = 1;
  endtask

  task automatic push(input int d);
    wr_i = 1; wr_data_i = 9'(d);
    step();
    wr_i = 0;
  endtask

  task automatic pop(output bit v, output int d);
    rd_i = 1;
    step();
    rd_i = 0;
    v = rd_valid_o;
    d = int'(rd_data_o);
  endtask

  task automatic pop_chk(input int exp, input string req);
    bit v; int d;
    pop(v, d);
    chk(v && d == exp, req, v ? d : -1, exp);
  endtask

  task automatic rewind();
    rt_i = 1;
    step();
    rt_i = 0;
  endtask

  task automatic t_reset();
    rst_ni = 0;
    #2;
    chk(empty_o && !full_o && !half_o && !rd_valid_o, "R1 in reset",
        {empty_o, full_o, half_o, rd_valid_o}, 8);
    do_reset();
    step();
    chk(empty_o && !full_o && !half_o && !rd_valid_o, "R1 after reset",
        {empty_o, full_o, half_o, rd_valid_o}, 8);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 5; i++) push(9'h0A0 + i);
    chk(!empty_o, "R5 not empty after write", empty_o, 0);
    for (int i = 0; i < 5; i++) pop_chk(9'h0A0 + i, "R2 order");
    chk(empty_o, "R5 empty after last read", empty_o, 1);
    step();
    chk(!rd_valid_o, "R2 valid drops", rd_valid_o, 0);
  endtask

  task automatic t_empty_read();
    bit v; int d;
    do_reset();
    pop(v, d);
    chk(!v && empty_o, "R4 read on empty ignored", v, 0);
    rd_i = 1; wr_i = 1; wr_data_i = 9'h155;
    step();
    rd_i = 0; wr_i = 0;
    chk(!rd_valid_o && !empty_o, "R9 empty rd+wr keeps write", {rd_valid_o, empty_o}, 0);
    pop_chk(9'h155, "R4 pointer not moved by ignored read");
    chk(empty_o, "R9 one word stored", empty_o, 1);
  endtask

  task automatic t_full();
    int bad = 0;
    bit v; int d;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      chk(!full_o, "R3 not full early", full_o, 0);
      push(i);
    end
    chk(full_o, "R3 full after DEPTH writes", full_o, 1);
    push(9'h1FF);
    chk(full_o, "R3 still full", full_o, 1);
    rd_i = 1; wr_i = 1; wr_data_i = 9'h1EE;
    step();
    rd_i = 0; wr_i = 0;
    chk(rd_valid_o && rd_data_o == 0, "R9 full rd+wr reads oldest", rd_data_o, 0);
    chk(!full_o, "R9 full rd+wr drops write", full_o, 0);
    for (int i = 1; i < DEPTH; i++) begin
      pop(v, d);
      if (!v || d != (i & 9'h1FF)) bad++;
    end
    chk(bad == 0, "R3 contents intact after blocked writes", bad, 0);
    chk(empty_o, "R3 no extra word stored", empty_o, 1);
  endtask

  task automatic t_half();
    do_reset();
    for (int i = 0; i < DEPTH / 2; i++) push(i);
    chk(!half_o, "R6 half clear at DEPTH/2", half_o, 0);
    push(9'h100);
    chk(half_o, "R6 half set above DEPTH/2", half_o, 1);
    rd_i = 1; wr_i = 1; wr_data_i = 9'h101;
    step();
    rd_i = 0; wr_i = 0;
    chk(half_o, "R9 half kept on rd+wr", half_o, 1);
    pop_chk(1, "R6 read order");
    chk(!half_o, "R6 half clear at DEPTH/2", half_o, 0);
  endtask

  task automatic t_rewind();
    do_reset();
    for (int i = 0; i < 10; i++) push(9'h030 + i);
    for (int i = 0; i < 10; i++) pop_chk(9'h030 + i, "R2 order before rewind");
    chk(empty_o, "R5 drained", empty_o, 1);
    rewind();
    chk(!empty_o, "R7 rewind recomputes empty", empty_o, 0);
    pop_chk(9'h030, "R7 rewind to first word");
    pop_chk(9'h031, "R7 second word after rewind");
    do_reset();
    for (int i = 0; i < 200; i++) push(i);
    for (int i = 0; i < 200; i++) pop_chk(i, "R2 order long");
    chk(!half_o, "R6 half clear when drained", half_o, 0);
    rewind();
    chk(half_o && !full_o, "R7 rewind recomputes half", half_o, 1);
  endtask

  task automatic t_expansion();
    do_reset();
    single_i = 0;
    for (int i = 0; i < 3; i++) push(9'h070 + i);
    pop_chk(9'h070, "R8 first read");
    rewind();
    pop_chk(9'h071, "R8 rewind ignored in expansion");
    for (int i = 0; i < 200; i++) push(i);
    chk(!half_o, "R8 half low in expansion", half_o, 0);
    single_i = 1;
  endtask

  task automatic t_rt_err();
    do_reset();
    for (int i = 0; i < 3; i++) push(9'h0C0 + i);
    pop_chk(9'h0C0, "R2 first");
    pop_chk(9'h0C1, "R2 second");
    rt_i = 1; rd_i = 1;
    #1;
    chk(rt_err_o, "R10 error flagged", rt_err_o, 1);
    step();
    rt_i = 0; rd_i = 0;
    chk(rd_valid_o && rd_data_o == 9'h0C2, "R10 read served, no rewind", rd_data_o, 9'h0C2);
    chk(empty_o, "R10 no rewind occupancy", empty_o, 1);
    step();
    chk(!rt_err_o, "R10 error clears", rt_err_o, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_empty_read();
    t_full();
    t_half();
    t_rewind();
    t_expansion();
    t_rt_err();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule